// File: doc/BRIEF.md
# Multi-Line Transmit DMA Sequencer

The block moves outgoing characters for a bank of serial lines (sixteen by default) from memory to each line's transmitter. Software picks a line through a select field in the control word, loads that line's 18-bit start address and the negated number of characters, and then sets the line's bit in the active mask. From then on the sequencer runs without help. It visits active lines in turn, reads one byte per visit over a simple request/acknowledge memory port, and offers the byte to that line's transmitter.

Each byte accepted moves the line's address up by one and its count up by one toward zero. When the count reaches zero, the line drops out of the active mask by itself and the shared transmit-interrupt flag is raised. A read that is never acknowledged retires the line and sets a memory-error flag. A per-line break mask holds chosen lines at the spacing level.

Toward the transmitters the block has one stream per line, with shared data. At most one `tx_valid` bit is high at a time. Once raised, it holds, with `tx_data` unchanged, until the same line's `tx_ready` is high at a clock edge. A transmitter that holds `tx_ready` low is skipped during arbitration and is never offered a byte. The memory side is not a stream: `mem_req` stays high with a fixed address until `mem_ack` is seen, and `mem_data` is taken in that same cycle.

Top module: `txdma_seq`

## Requirements
- R1: After reset, every register reads zero, `mem_req`, every `tx_valid` bit, `line_break` and `tx_irq` are low, and arbitration begins at line 0.
- R2: Control bits 3:0 (offset 0) choose the line whose address low half (offset 1) and count (offset 2) are read and written. A control write loads control bits 5:4 into address bits 17:16 of the newly chosen line. Reading control returns the chosen line in bits 3:0 and that line's address bits 17:16 in bits 5:4.
- R3: Writing the active mask (offset 3) starts each line whose data bit is 1. Zero bits in the write have no effect. A line's bit clears by itself when its count reaches zero.
- R4: For a count loaded as -n, a line delivers exactly n bytes, read from consecutive addresses starting at the loaded one and offered in address order. Address and count each step by one per accepted byte, so at the end the address names the byte after the last one and the count reads zero.
- R5: Control bit 15 is set whenever a line retires, whether by completion or by a memory error. A control write with bit 15 at 0 clears it, and writing 1 there leaves it unchanged. Bit 13 is an enable, and `tx_irq` equals bit 15 AND bit 13.
- R6: At most one `tx_valid` bit is high at a time. A raised bit holds, with `tx_data` stable, until that line's `tx_ready` is high at a clock edge.
- R7: Lines are served round-robin, one byte per visit, with the search starting at the line after the one last served. A line whose `tx_ready` is low is passed over and keeps its address, count and active bit.
- R8: Writing a count of 0xFFFF to an active line makes it accept at most one further byte and then retire. Its address then shows where output stopped.
- R9: A memory request is abandoned if no acknowledge arrives within 16 cycles. An acknowledge in the 16th cycle is still taken. When the request is abandoned, control bit 10 is set, the line retires with no byte offered, and its count is unchanged. A control write with bit 8 set clears bit 10.
- R10: The break mask (offset 4) reads back as written and drives `line_break`. A set bit holds that line at the spacing level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory read request, held until acknowledged or abandoned |
| mem_addr | output | 18 | Byte address of the read |
| mem_ack | input | 1 | Read acknowledge; `mem_data` is valid in this cycle |
| mem_data | input | 8 | Read byte |
| tx_valid | output | 16 | Per-line byte offer |
| tx_data | output | 8 | Byte shared by all line offers |
| tx_ready | input | 16 | Per-line transmitter ready |
| line_break | output | 16 | Per-line force-to-spacing |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A directed run on three lines, with every transmitter ready and zero memory latency, fixes the exact round-robin order of service. A held-off line running beside a free one shows that skipping leaves the held line's state untouched. Random rounds use random line subsets, start addresses, lengths, memory latencies and ready patterns, and check each line's byte stream and final address. The ready patterns separate a design that holds its offer from one that drops or changes it. Directed cases place an acknowledge exactly at the 16th cycle and then one cycle later, run a transfer whose address carries into bit 16, and abort a long transfer by writing a count of 0xFFFF. They separate an off-by-one timeout, a lost carry and an abort that overshoots.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int ADDR_W = 18;
  localparam int WORD_W = 16;
  localparam int HI_W   = ADDR_W - WORD_W;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_ADDR   = 3'd1;
  localparam logic [2:0] RA_COUNT  = 3'd2;
  localparam logic [2:0] RA_ACTIVE = 3'd3;
  localparam logic [2:0] RA_BREAK  = 3'd4;

  localparam int CB_HI      = 4;
  localparam int CB_CLR_NXM = 8;
  localparam int CB_NXM     = 10;
  localparam int CB_IE      = 13;
  localparam int CB_FLAG    = 15;

  typedef enum logic [1:0] {S_PICK, S_FETCH, S_SEND} seq_state_e;
endpackage

// File: rtl/txdma_rr_arb.sv
module txdma_rr_arb #(
  parameter int N = 16,
  localparam int SW = $clog2(N)
)(
  input  logic [N-1:0]  req,
  input  logic [SW-1:0] start,
  output logic          found,
  output logic [SW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = start;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(start) + k) % N;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = SW'(idx);
      end
    end
  end
endmodule

// File: rtl/txdma_fetch_timer.sv
module txdma_fetch_timer #(
  parameter int LIMIT = 16,
  localparam int CW = $clog2(LIMIT + 1)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic ack,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  assign expired = waiting && !ack && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!waiting || ack) cnt_q <= '0;
    else if (!expired)        cnt_q <= cnt_q + 1'b1;
  end

  // R9: wait counter never passes the limit
  p_timer_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/txdma_linefile.sv
module txdma_linefile
  import txdma_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int SEL_W = $clog2(N_LINES)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic               wr_cnt,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [HI_W-1:0]    hi_wdata,
  input  logic               adv,
  input  logic [SEL_W-1:0]   adv_line,
  output logic [ADDR_W-1:0]  sel_addr,
  output logic [WORD_W-1:0]  sel_cnt,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [N_LINES-1:0] finished
);
  logic [ADDR_W-1:0] addr_arr [N_LINES];
  logic [WORD_W-1:0] cnt_arr  [N_LINES];

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic [ADDR_W-1:0] a_q, a_d;
    logic [WORD_W-1:0] c_q, c_d;
    logic              hit_host, hit_adv;

    assign hit_host = (wr_sel == SEL_W'(i));
    assign hit_adv  = adv && (adv_line == SEL_W'(i));

    // host write applies first, a same-cycle advance then steps the result
    always_comb begin
      a_d = a_q;
      c_d = c_q;
      if (hit_host && wr_hi)  a_d[ADDR_W-1:WORD_W] = hi_wdata;
      if (hit_host && wr_lo)  a_d[WORD_W-1:0]      = wdata;
      if (hit_host && wr_cnt) c_d                  = wdata;
      if (hit_adv) begin
        a_d = a_d + 1'b1;
        c_d = c_d + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q <= '0;
        c_q <= '0;
      end else begin
        a_q <= a_d;
        c_q <= c_d;
      end
    end

    assign finished[i] = hit_adv && (c_d == '0);
    assign addr_arr[i] = a_q;
    assign cnt_arr[i]  = c_q;
  end

  assign sel_addr = addr_arr[rd_sel];
  assign sel_cnt  = cnt_arr[rd_sel];
  assign cur_addr = addr_arr[adv_line];
endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
  import txdma_pkg::*;
#(
  parameter int N_LINES    = 16,
  parameter int TMO_CYCLES = 16,
  parameter int DATA_W     = 8
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_data,
  output logic [N_LINES-1:0] tx_valid,
  output logic [DATA_W-1:0]  tx_data,
  input  logic [N_LINES-1:0] tx_ready,
  output logic [N_LINES-1:0] line_break,
  output logic               tx_irq
);
  localparam int SEL_W = $clog2(N_LINES);

  seq_state_e        state_q;
  logic [SEL_W-1:0]  sel_q, cur_q, ptr_q, pick_idx, nxt_line, wr_sel;
  logic [DATA_W-1:0] byte_q;
  logic [N_LINES-1:0] active_q, brk_q, elig, cur_hot, done_vec, retire;
  logic              ie_q, flag_q, nxm_q, any_elig, tmo_hit, adv;
  logic              wr_ctrl, wr_addr, wr_count, wr_active, wr_break;
  logic [ADDR_W-1:0] sel_addr, cur_addr;
  logic [WORD_W-1:0] sel_cnt, ctrl_rd;

  assign wr_ctrl   = reg_we && (reg_addr == RA_CTRL);
  assign wr_addr   = reg_we && (reg_addr == RA_ADDR);
  assign wr_count  = reg_we && (reg_addr == RA_COUNT);
  assign wr_active = reg_we && (reg_addr == RA_ACTIVE);
  assign wr_break  = reg_we && (reg_addr == RA_BREAK);
  assign wr_sel    = wr_ctrl ? reg_wdata[SEL_W-1:0] : sel_q;

  assign elig     = active_q & tx_ready;
  assign cur_hot  = N_LINES'(1) << cur_q;
  assign nxt_line = (cur_q == SEL_W'(N_LINES - 1)) ? '0 : cur_q + 1'b1;
  assign adv      = (state_q == S_SEND) && tx_ready[cur_q];
  assign retire   = done_vec | ((tmo_hit) ? cur_hot : '0);

  txdma_rr_arb #(.N(N_LINES)) u_arb (
    .req(elig), .start(ptr_q), .found(any_elig), .pick(pick_idx)
  );

  txdma_fetch_timer #(.LIMIT(TMO_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .waiting(state_q == S_FETCH),
    .ack(mem_ack), .expired(tmo_hit)
  );

  txdma_linefile #(.N_LINES(N_LINES)) u_lines (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .rd_sel(sel_q),
    .wr_lo(wr_addr), .wr_hi(wr_ctrl), .wr_cnt(wr_count),
    .wdata(reg_wdata), .hi_wdata(reg_wdata[CB_HI +: HI_W]),
    .adv(adv), .adv_line(cur_q),
    .sel_addr(sel_addr), .sel_cnt(sel_cnt), .cur_addr(cur_addr),
    .finished(done_vec)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_PICK;
      cur_q   <= '0;
      ptr_q   <= '0;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        S_PICK: if (any_elig) begin
          cur_q   <= pick_idx;
          state_q <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          byte_q  <= mem_data;
          state_q <= S_SEND;
        end else if (tmo_hit) begin
          ptr_q   <= nxt_line;
          state_q <= S_PICK;
        end
        S_SEND: if (tx_ready[cur_q]) begin
          ptr_q   <= nxt_line;
          state_q <= S_PICK;
        end
        default: state_q <= S_PICK;
      endcase
    end
  end

  // host-visible state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      nxm_q    <= 1'b0;
      active_q <= '0;
      brk_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_q <= reg_wdata[SEL_W-1:0];
        ie_q  <= reg_wdata[CB_IE];
      end
      if (|retire)                           flag_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata[CB_FLAG]) flag_q <= 1'b0;
      if (tmo_hit)                              nxm_q <= 1'b1;
      else if (wr_ctrl && reg_wdata[CB_CLR_NXM]) nxm_q <= 1'b0;
      active_q <= (active_q & ~retire) | (wr_active ? reg_wdata[N_LINES-1:0] : '0);
      if (wr_break) brk_q <= reg_wdata[N_LINES-1:0];
    end
  end

  always_comb begin
    ctrl_rd                 = '0;
    ctrl_rd[SEL_W-1:0]      = sel_q;
    ctrl_rd[CB_HI +: HI_W]  = sel_addr[ADDR_W-1 -: HI_W];
    ctrl_rd[CB_NXM]         = nxm_q;
    ctrl_rd[CB_IE]          = ie_q;
    ctrl_rd[CB_FLAG]        = flag_q;
  end

  always_comb begin
    unique case (reg_addr)
      RA_CTRL:   reg_rdata = ctrl_rd;
      RA_ADDR:   reg_rdata = sel_addr[WORD_W-1:0];
      RA_COUNT:  reg_rdata = sel_cnt;
      RA_ACTIVE: reg_rdata = WORD_W'(active_q);
      RA_BREAK:  reg_rdata = WORD_W'(brk_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign mem_req    = (state_q == S_FETCH);
  assign mem_addr   = cur_addr;
  assign tx_valid   = (state_q == S_SEND) ? cur_hot : '0;
  assign tx_data    = byte_q;
  assign line_break = brk_q;
  assign tx_irq     = flag_q & ie_q;

  // R6: only one line is offered a byte at a time
  p_single_sink_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid));
  // R6: an offer is held unchanged until taken
  p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_valid & ~tx_ready)) |=> ($stable(tx_valid) && $stable(tx_data)));
  // R5: any retirement leaves the interrupt flag set
  p_retire_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|retire) |=> flag_q);
  // R7: a granted line is active and ready
  p_grant_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PICK && any_elig) |-> elig[pick_idx]);
  // R9: an abandoned read drops the request and the line
  p_expiry_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !wr_active) |=> (!mem_req && !active_q[$past(cur_q)] && nxm_q));
endmodule

// File: tb/txdma_seq_test.sv
module txdma_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_ADDR = 3'd1, A_CNT = 3'd2, A_ACT = 3'd3, A_BRK = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [17:0] mem_addr;
  logic [7:0] mem_data = '0, tx_data;
  logic [15:0] tx_valid, tx_ready = '1, line_break;
  logic tx_irq;

  txdma_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .line_break(line_break), .tx_irq(tx_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int got [16];
  logic [17:0] base [16];
  int ord [64];
  int ord_n = 0, bad_data = 0, mem_lat = 0;
  bit rdy_rand = 0, ie = 1;
  logic [15:0] rdy_mask = '1;
  logic [15:0] rv;

  function automatic logic [7:0] mem_byte(input logic [17:0] a);
    return (a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]}) + 8'h5a;
  endfunction

  function automatic logic [15:0] ctrl_word(input int l, input logic [1:0] hi, input bit clr);
    return 16'h8000 | (ie ? 16'h2000 : 16'h0) | (clr ? 16'h0100 : 16'h0) |
           {10'd0, hi, 4'(l)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    reg_addr = a;
    #1 rv = reg_rdata;
  endtask

  task automatic setup(input int l, input logic [1:0] hi, input logic [15:0] lo, input int n);
    wr(A_CTRL, ctrl_word(l, hi, 0));
    wr(A_ADDR, lo);
    wr(A_CNT, 16'(-n));
    base[l] = {hi, lo};
    got[l] = 0;
  endtask

  task automatic wait_idle(input int limit);
    for (int k = 0; k < limit; k++) begin
      rd(A_ACT);
      if (rv == 16'h0) break;
    end
  endtask

  // transmitter model: change ready after the edge, record handshakes before the next
  initial forever begin
    @(posedge clk); #1;
    tx_ready = (rdy_rand ? 16'($urandom) : 16'hffff) & rdy_mask;
    @(negedge clk);
    for (int i = 0; i < 16; i++)
      if (tx_valid[i] && tx_ready[i]) begin
        if (tx_data !== mem_byte(base[i] + 18'(got[i]))) bad_data++;
        got[i]++;
        if (ord_n < 64) begin ord[ord_n] = i; ord_n++; end
      end
  end

  // memory model: addresses with bits 17:16 == 3 never answer
  initial begin
    int wt;
    wt = 0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (!mem_ack && mem_addr[17:16] != 2'b11 && wt == mem_lat) begin
          mem_ack = 1'b1; mem_data = mem_byte(mem_addr);
        end else mem_ack = 1'b0;
        wt++;
      end else begin
        mem_ack = 1'b0; wt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seed_dummy, snap;
    seed_dummy = $urandom(32'h5eed);
    for (int i = 0; i < 16; i++) begin got[i] = 0; base[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL);  check("R1 ctrl", rv, 0);
    rd(A_ACT);   check("R1 active", rv, 0);
    check("R1 outputs", {tx_valid, mem_req, tx_irq, line_break}, 0);

    // R7 round-robin order with all transmitters ready
    for (int l = 0; l < 3; l++) setup(l, 2'd0, 16'(l * 16'h100), 3);
    ord_n = 0;
    wr(A_ACT, 16'h0007);
    wait_idle(200);
    begin
      bit ok; ok = (ord_n == 9);
      for (int k = 0; k < 9; k++) if (ord[k] != k % 3) ok = 0;
      check("R7 service order", ok, 1);
    end

    // R2/R4 directed, address carry into bit 16
    setup(7, 2'd1, 16'hfffe, 3);
    wr(A_ACT, 16'h0080);
    wait_idle(200);
    check("R4 line7 bytes", got[7], 3);
    rd(A_CTRL);  check("R2 ctrl sel+hi", rv[5:0], {2'd2, 4'd7});
    rd(A_ADDR);  check("R4 end address", rv, 16'h0001);
    rd(A_CNT);   check("R4 end count", rv, 0);
    rd(A_CTRL);  check("R5 flag set", rv[15], 1);
    check("R5 irq pin", tx_irq, 1);
    wr(A_CTRL, ctrl_word(7, 2'd2, 0) | 16'h8000);
    check("R5 write1 keeps flag", tx_irq, 1);
    wr(A_CTRL, ctrl_word(7, 2'd2, 0) & ~16'h8000);
    rd(A_CTRL);  check("R5 flag cleared", rv[15], 0);

    // R7 skip: line 5 held off, line 6 free; R3 zero write ignored
    rdy_mask = 16'hffdf;
    setup(5, 2'd0, 16'h0500, 2);
    setup(6, 2'd0, 16'h0600, 3);
    wr(A_ACT, 16'h0060);
    for (int k = 0; k < 200; k++) begin rd(A_ACT); if (rv == 16'h0020) break; end
    check("R7 free line done", got[6], 3);
    check("R7 held line untouched", got[5], 0);
    wr(A_ACT, 16'h0000);
    rd(A_ACT);   check("R3 zero write ignored", rv, 16'h0020);
    wr(A_CTRL, ctrl_word(5, 2'd0, 0));
    rd(A_CNT);   check("R7 held count kept", rv, 16'hfffe);
    rdy_mask = 16'hffff;
    wait_idle(200);
    check("R3 held line completes", got[5], 2);

    // R9 nxm region never answers
    setup(9, 2'd3, 16'h0010, 2);
    wr(A_ACT, 16'h0200);
    wait_idle(200);
    rd(A_CTRL);  check("R9 nxm flag", rv[10], 1);
    check("R9 no bytes", got[9], 0);
    check("R5 irq on error", tx_irq, 1);
    rd(A_CNT);   check("R9 count unchanged", rv, 16'hfffe);
    wr(A_CTRL, ctrl_word(9, 2'd3, 1));
    rd(A_CTRL);  check("R9 nxm cleared", rv[10], 0);

    // R9 acknowledge boundary
    mem_lat = 15;
    setup(4, 2'd0, 16'h0040, 1);
    wr(A_ACT, 16'h0010);
    wait_idle(200);
    rd(A_CTRL);  check("R9 ack at 16th accepted", {rv[10], 8'(got[4])}, {1'b0, 8'd1});
    mem_lat = 16;
    setup(4, 2'd0, 16'h0080, 1);
    wr(A_ACT, 16'h0010);
    wait_idle(200);
    rd(A_CTRL);  check("R9 ack at 17th refused", {rv[10], 8'(got[4])}, {1'b1, 8'd0});
    wr(A_CTRL, ctrl_word(4, 2'd0, 1));
    mem_lat = 0;

    // R5 enable gating
    ie = 0;
    wr(A_CTRL, ctrl_word(1, 2'd0, 0) & ~16'h8000);
    setup(1, 2'd0, 16'h1000, 1);
    wr(A_ACT, 16'h0002);
    wait_idle(200);
    rd(A_CTRL);  check("R5 flag with ie off", {rv[15], rv[13]}, 2'b10);
    check("R5 irq gated", tx_irq, 0);
    ie = 1;
    wr(A_CTRL, ctrl_word(1, 2'd0, 0));
    check("R5 irq enabled", tx_irq, 1);

    // R8 abort with count 0xffff
    rdy_rand = 1;
    setup(2, 2'd1, 16'h2000, 200);
    wr(A_ACT, 16'h0004);
    for (int k = 0; k < 2000 && got[2] < 10; k++) @(negedge clk);
    wr(A_CTRL, ctrl_word(2, 2'd1, 0));
    wr(A_CNT, 16'hffff);
    snap = got[2];
    wait_idle(500);
    check("R8 at most one more", (got[2] - snap) <= 1, 1);
    rd(A_ADDR);  check("R8 stop address", rv, 16'h2000 + 16'(got[2]));

    // R4/R6 random rounds
    for (int r = 0; r < 8; r++) begin
      logic [15:0] m;
      int n [16];
      bit ok;
      m = 16'($urandom) | 16'h0001;
      mem_lat = $urandom % 5;
      for (int l = 0; l < 16; l++) if (m[l]) begin
        n[l] = 1 + $urandom % 6;
        setup(l, 2'($urandom % 3), 16'($urandom % 16'hff00), n[l]);
      end
      wr(A_ACT, m);
      wait_idle(5000);
      ok = 1;
      for (int l = 0; l < 16; l++) if (m[l]) begin
        if (got[l] != n[l]) ok = 0;
        wr(A_CTRL, ctrl_word(l, base[l][17:16], 0));
        rd(A_ADDR);
        if (rv != base[l][15:0] + 16'(n[l])) ok = 0;
      end
      check($sformatf("R4 random round %0d", r), ok, 1);
    end
    check("R4 R6 byte values", bad_data, 0);
    rdy_rand = 0;

    // R10 break register
    wr(A_BRK, 16'h8421);
    rd(A_BRK);   check("R10 break readback", rv, 16'h8421);
    check("R10 break output", line_break, 16'h8421);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule